// File: doc/BRIEF.md
# Multi-core interrupt broadcast and claim unit

This unit fans a set of external interrupt lines out to several processor cores. Each interrupt has a routing register and a claim register. The routing register holds one bit per core, and only the cores whose bits are set see that interrupt. The claim register lets one receiving core take ownership. After a successful claim, only the owner keeps receiving the line. The owner gives the interrupt back by rewriting the all-ones pattern.

Every core has its own single-cycle register port: a write strobe, a word address and 32 bits of write data. Read data on that port is combinational from the address. If several ports write the same register in one clock, the lowest-numbered port decides the result. A core claims an interrupt by writing a word with only its own bit set. It then reads the register back: the claim succeeded when the read value equals that word.

Top module: `irq_share_unit`

## Requirements
- R1: Routing register i holds NUM_CORES bits. Bit c set lets core c receive interrupt i. A write loads wdata[NUM_CORES-1:0]. A read returns that value zero-extended to 32 bits.
- R2: After reset, every routing register reads 1 (core 0 only) and every claim register reads 32'hFFFF_FFFF (unclaimed).
- R3: Word address bit IDX_W selects the region: 0 for routing, 1 for claim. Bits [IDX_W-1:0] give the interrupt index. A write is captured at the clock edge that samples its strobe and is visible from the next cycle on. Read data follows the address in the same cycle.
- R4: A write to an unclaimed claim register of a word with exactly one bit n set, where n < NUM_CORES, makes the register read 1<<n.
- R5: While an interrupt is claimed, claim writes other than all ones are ignored. A claim write that is neither all ones nor a valid one-hot word is always ignored.
- R6: Writing 32'hFFFF_FFFF to a claim register releases it, so it reads all ones again.
- R7: When several ports write the same register in one cycle, only the lowest-numbered port's write applies. This holds for routing and for claim. For claim, only release and valid one-hot writes compete.
- R8: core_irq[c*NUM_IRQS+i] is high exactly when irq_in[i] is high, routing bit c of interrupt i is set, and claim register i is either all ones or has bit c set.
- R9: A write to an interrupt index of NUM_IRQS or above has no effect, and a read from such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IRQS | External interrupt lines |
| core_wr | input | NUM_CORES | Per-core write strobe |
| core_addr | input | NUM_CORES*(IDX_W+1) | Per-core word address, core c at slice c |
| core_wdata | input | NUM_CORES*32 | Per-core write data |
| core_rdata | output | NUM_CORES*32 | Per-core read data, combinational from address |
| core_irq | output | NUM_CORES*NUM_IRQS | Request for core c, interrupt i at bit c*NUM_IRQS+i |

## Verification
Read data and request outputs are combinational. A register write only shows up after the clock edge that samples its strobe. The bench therefore drives every access on the falling edge and holds write strobes across exactly one rising edge. It samples reads and requests 1 ns after the falling edge that follows. The reference model is updated at that same point, so every comparison sees the register state as it stands after the capturing edge and before the next one.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] UNCLAIMED = '1;

  // Valid claim word: exactly one bit set, and that bit addresses an existing core.
  function automatic logic claim_word_ok(input logic [WORD_W-1:0] w, input int unsigned nc);
    logic [WORD_W-1:0] beyond;
    beyond = (nc >= WORD_W) ? '0 : ~((WORD_W'(1) << nc) - WORD_W'(1));
    return ($countones(w) == 1) && ((w & beyond) == '0);
  endfunction

  // Request gating for a single core: line high, routed, and owner or free.
  function automatic logic gate_req(input logic line, input logic routed,
                                    input logic held, input logic owns);
    return line & routed & (~held | owns);
  endfunction
endpackage

// File: rtl/irq_share_slot.sv
module irq_share_slot
  import irq_share_pkg::*;
#(
  parameter int unsigned NC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 irq_line,
  input  logic [NC-1:0]        route_we,
  input  logic [NC-1:0]        claim_we,
  input  logic [NC*WORD_W-1:0] wdata_all,
  output logic [NC-1:0]        route_q,
  output logic [WORD_W-1:0]    claim_word,
  output logic [NC-1:0]        req
);
  logic          held_q;
  logic [NC-1:0] owner_q;
  logic [NC-1:0] route_nxt;
  logic          route_hit;
  logic          win_release;
  logic          win_claim;
  logic [NC-1:0] claim_val;
  logic          claim_take;

  // Scan from the top port down so the lowest-numbered writer overrides.
  always_comb begin
    route_hit   = 1'b0;
    route_nxt   = route_q;
    win_release = 1'b0;
    win_claim   = 1'b0;
    claim_val   = '0;
    for (int p = NC - 1; p >= 0; p--) begin
      if (route_we[p]) begin
        route_hit = 1'b1;
        route_nxt = wdata_all[p*WORD_W +: NC];
      end
      if (claim_we[p]) begin
        if (wdata_all[p*WORD_W +: WORD_W] == UNCLAIMED) begin
          win_release = 1'b1;
          win_claim   = 1'b0;
          claim_val   = '0;
        end else if (claim_word_ok(wdata_all[p*WORD_W +: WORD_W], NC)) begin
          win_release = 1'b0;
          win_claim   = 1'b1;
          claim_val   = wdata_all[p*WORD_W +: NC];
        end
      end
    end
  end

  assign claim_take = win_claim & ~held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= NC'(1);
    end else if (route_hit) begin
      route_q <= route_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (win_release) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (claim_take) begin
      held_q  <= 1'b1;
      owner_q <= claim_val;
    end
  end

  assign claim_word = held_q ? WORD_W'(owner_q) : UNCLAIMED;

  for (genvar c = 0; c < NC; c++) begin : g_req
    assign req[c] = gate_req(irq_line, route_q[c], held_q, owner_q[c]);
  end

  // R5
  claim_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !win_release) |=> (held_q && $stable(owner_q)));

  // R4
  claim_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_q && win_claim && !win_release) |=> (held_q && owner_q == $past(claim_val)));

  // R6
  claim_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_release |=> (!held_q && claim_word == UNCLAIMED));

  // R4
  claim_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> ($countones(owner_q) == 1));

  // R8
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> ($countones(req) <= 1));
endmodule

// File: rtl/irq_share_rdmux.sv
module irq_share_rdmux
  import irq_share_pkg::*;
#(
  parameter int unsigned NI    = 6,
  parameter int unsigned NC    = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W:0]       addr,
  input  logic [NI*NC-1:0]     route_all,
  input  logic [NI*WORD_W-1:0] claim_all,
  output logic [WORD_W-1:0]    rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NI; i++) begin
      if (addr[IDX_W-1:0] == IDX_W'(i)) begin
        rdata = addr[IDX_W] ? claim_all[i*WORD_W +: WORD_W]
                            : WORD_W'(route_all[i*NC +: NC]);
      end
    end
  end
endmodule

// File: rtl/irq_share_unit.sv
module irq_share_unit
  import irq_share_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_IRQS  = 6,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_IRQS-1:0]             irq_in,
  input  logic [NUM_CORES-1:0]            core_wr,
  input  logic [NUM_CORES*(IDX_W+1)-1:0]  core_addr,
  input  logic [NUM_CORES*32-1:0]         core_wdata,
  output logic [NUM_CORES*32-1:0]         core_rdata,
  output logic [NUM_CORES*NUM_IRQS-1:0]   core_irq
);
  localparam int unsigned AW = IDX_W + 1;

  logic [NUM_CORES-1:0]       route_we [NUM_IRQS];
  logic [NUM_CORES-1:0]       claim_we [NUM_IRQS];
  logic [NUM_CORES-1:0]       slot_route [NUM_IRQS];
  logic [NUM_CORES-1:0]       slot_req [NUM_IRQS];
  logic [NUM_IRQS*NUM_CORES-1:0] route_flat;
  logic [NUM_IRQS*WORD_W-1:0]    claim_flat;

  // Decode each port's address into per-interrupt write strobes.
  always_comb begin
    for (int i = 0; i < NUM_IRQS; i++) begin
      for (int p = 0; p < NUM_CORES; p++) begin
        route_we[i][p] = core_wr[p] && !core_addr[p*AW + IDX_W]
                         && (core_addr[p*AW +: IDX_W] == IDX_W'(i));
        claim_we[i][p] = core_wr[p] && core_addr[p*AW + IDX_W]
                         && (core_addr[p*AW +: IDX_W] == IDX_W'(i));
      end
    end
  end

  for (genvar i = 0; i < NUM_IRQS; i++) begin : g_slot
    irq_share_slot #(.NC(NUM_CORES)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_line   (irq_in[i]),
      .route_we   (route_we[i]),
      .claim_we   (claim_we[i]),
      .wdata_all  (core_wdata),
      .route_q    (slot_route[i]),
      .claim_word (claim_flat[i*WORD_W +: WORD_W]),
      .req        (slot_req[i])
    );
    assign route_flat[i*NUM_CORES +: NUM_CORES] = slot_route[i];
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_out
      assign core_irq[c*NUM_IRQS + i] = slot_req[i][c];
    end
  end

  for (genvar p = 0; p < NUM_CORES; p++) begin : g_port
    irq_share_rdmux #(.NI(NUM_IRQS), .NC(NUM_CORES), .IDX_W(IDX_W)) u_rd (
      .addr      (core_addr[p*AW +: AW]),
      .route_all (route_flat),
      .claim_all (claim_flat),
      .rdata     (core_rdata[p*WORD_W +: WORD_W])
    );
  end

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in == '0) |-> (core_irq == '0));
endmodule

// File: tb/test_irq_share_unit.sv
`timescale 1ns/1ps
module test_irq_share_unit;
  localparam int NC = 4;
  localparam int NI = 6;
  localparam int AW = 4;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NI-1:0]    irq_in = '0;
  logic [NC-1:0]    core_wr = '0;
  logic [NC*AW-1:0] core_addr = '0;
  logic [NC*32-1:0] core_wdata = '0;
  logic [NC*32-1:0] core_rdata;
  logic [NC*NI-1:0] core_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0]  route_m [NI];
  logic [31:0] claim_m [NI];

  always #2.5 clk = ~clk;

  irq_share_unit #(.NUM_CORES(NC), .NUM_IRQS(NI), .IDX_W(3)) i_irq_share_unit (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .core_wr(core_wr),
    .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_irq(core_irq));

  // Vector: {write, port[1:0], addr[3:0], data[31:0], expected read[31:0]}
  // Routing irq i at address i, claim irq i at address 8+i.
  localparam int NV = 16;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'd0,  32'h0,        32'h1},        // R2 routing reset
    {1'b0, 2'd1, 4'd10, 32'h0,        ONES},         // R2 claim reset
    {1'b1, 2'd0, 4'd2,  32'h0000_000E, 32'h0},       // R1 route irq2
    {1'b0, 2'd3, 4'd2,  32'h0,        32'hE},        // R1 R3 read back
    {1'b1, 2'd1, 4'd10, 32'h2,        32'h0},        // R4 core1 claims irq2
    {1'b0, 2'd1, 4'd10, 32'h0,        32'h2},        // R4
    {1'b1, 2'd2, 4'd10, 32'h4,        32'h0},        // R5 late claim
    {1'b0, 2'd2, 4'd10, 32'h0,        32'h2},        // R5
    {1'b1, 2'd3, 4'd10, 32'h5,        32'h0},        // R5 junk word
    {1'b0, 2'd0, 4'd10, 32'h0,        32'h2},        // R5
    {1'b1, 2'd1, 4'd10, ONES,         32'h0},        // R6 release
    {1'b0, 2'd1, 4'd10, 32'h0,        ONES},         // R6
    {1'b1, 2'd0, 4'd11, 32'h10,       32'h0},        // R4 bit beyond cores
    {1'b0, 2'd0, 4'd11, 32'h0,        ONES},         // R4 still free
    {1'b1, 2'd0, 4'd7,  32'hF,        32'h0},        // R9 out of range
    {1'b0, 2'd2, 4'd7,  32'h0,        32'h0}         // R9 reads zero
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model_wr(input logic [3:0] a, input logic [31:0] d);
    int i;
    i = int'(a[2:0]);
    if (i >= NI) return;
    if (!a[3]) route_m[i] = d[3:0];
    else if (d == ONES) claim_m[i] = ONES;
    else if (claim_m[i] == ONES && $countones(d) == 1 && d < 32'd16) claim_m[i] = d;
  endfunction

  function automatic logic [31:0] exp_irq();
    logic [31:0] v;
    v = '0;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++)
        v[c*NI+i] = irq_in[i] && route_m[i][c] && (claim_m[i] == ONES || claim_m[i][c]);
    return v;
  endfunction

  task automatic wr1(input int p, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    core_wr[p] = 1'b1; core_addr[p*AW +: AW] = a; core_wdata[p*32 +: 32] = d;
    @(negedge clk);
    core_wr = '0;
    model_wr(a, d);
  endtask

  task automatic wr2(input int pa, input logic [3:0] aa, input logic [31:0] da,
                     input int pb, input logic [3:0] ab, input logic [31:0] db);
    @(negedge clk);
    core_wr[pa] = 1'b1; core_addr[pa*AW +: AW] = aa; core_wdata[pa*32 +: 32] = da;
    core_wr[pb] = 1'b1; core_addr[pb*AW +: AW] = ab; core_wdata[pb*32 +: 32] = db;
    @(negedge clk);
    core_wr = '0;
  endtask

  task automatic rd(input int p, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    core_addr[p*AW +: AW] = a;
    #1 d = core_rdata[p*32 +: 32];
  endtask

  task automatic chk_irq(input string tag);
    #1 chk(tag, 32'(core_irq), exp_irq());
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < NI; i++) begin route_m[i] = 4'h1; claim_m[i] = ONES; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_in = '1;
    chk_irq("R2 R8 reset routing core0 only");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][70]) wr1(int'(VEC[v][69:68]), VEC[v][67:64], VEC[v][63:32]);
      else begin
        rd(int'(VEC[v][69:68]), VEC[v][67:64], r);
        chk($sformatf("R1-table vector %0d", v), r, VEC[v][31:0]);
      end
    end
    chk_irq("R8 after table");

    // R7: two claims in one cycle, port 1 beats port 3
    wr2(1, 4'd8, 32'h2, 3, 4'd8, 32'h8);
    claim_m[0] = 32'h2;
    rd(0, 4'd8, r); chk("R7 claim tie", r, 32'h2);

    // R7: two routing writes in one cycle, port 0 beats port 2
    wr2(0, 4'd4, 32'h3, 2, 4'd4, 32'hC);
    route_m[4] = 4'h3;
    rd(3, 4'd4, r); chk("R7 route tie", r, 32'h3);

    // R8: claimed irq0 reaches only its owner
    wr1(2, 4'd0, 32'hF);
    chk_irq("R8 owner only");
    chk(" R8 irq0 lines", {28'h0, core_irq[3*NI], core_irq[2*NI], core_irq[NI], core_irq[0]}, 32'h2);

    // R6: release reopens all routed cores
    wr1(1, 4'd8, ONES);
    chk_irq("R6 R8 release");

    // R9: out-of-range writes change nothing visible
    wr1(0, 4'd6, 32'h0);
    wr1(0, 4'd14, 32'h1);
    chk_irq("R9 no effect");
    rd(1, 4'd14, r); chk("R9 claim read zero", r, 32'h0);

    // R7: release on port 0 beats a claim on port 2 in the same cycle
    wr2(0, 4'd11, ONES, 2, 4'd11, 32'h4);
    rd(2, 4'd11, r); chk("R7 release wins", r, ONES);

    // R8: line low gates everything
    irq_in = 6'b101010;
    chk_irq("R8 partial lines");
    irq_in = '0;
    chk_irq("R8 quiet");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule